// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves data between an A bus and a B bus. It is split into independent byte-wide channels, two by default. Each channel has one path from A to B and one path from B to A. Each path has its own capture register, its own capture clock, a select and an output enable. The select decides whether the far bus is driven with the live value of the near bus or with the value captured in the register. The capture clocks load their registers on every rising edge, whatever the selects and enables are doing.

Each bidirectional bus appears as three vectors: the resolved bus value coming in, the value the block would drive, and a per-bit drive enable. A wrapper can join these into real tri-state pins. A power-good input models the unpowered state at the logic level: while it is low, every drive enable is forced off. If both paths of a channel are live and enabled, each output copies the other bus. Once the external drivers release the buses, the buses keep their last value.

Top module: `reg_xcvr`

## Requirements
- R1: Each 8-bit channel c covers bus bits [8c+7:8c] and has its own clocks, selects and enables. Any activity on one channel's controls, clocks or data leaves the other channel's outputs, drive enables and stored values unchanged.
- R2: A rising edge on `clk_ab_i[c]` loads the channel's A-bus byte into its A-side register. A rising edge on `clk_ba_i[c]` loads the B-bus byte into its B-side register.
- R3: Capture takes place on every rising clock edge, with either select value and with the path's output enable on or off.
- R4: With `sel_ab_i[c]` low, `b_o` carries the live A-bus byte of the channel. With it high, `b_o` carries the A-side register.
- R5: With `sel_ba_i[c]` low, `a_o` carries the live B-bus byte of the channel. With it high, `a_o` carries the B-side register.
- R6: `b_oe_o` for the channel's byte is all ones when `en_ab_i[c]` is high (active high) and all zeros when it is low.
- R7: `a_oe_o` for the channel's byte is all ones when `en_ba_ni[c]` is low (active low) and all zeros when it is high.
- R8: While `pwr_good_i` is low, every bit of `a_oe_o` and `b_oe_o` is zero, whatever the enables are.
- R9: With both selects low and both enables active, `b_o` equals `a_i` and `a_o` equals `b_i`. After the external drivers release, both buses therefore keep the last value that was driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pwr_good_i | input | 1 | Supply good; low forces all drive enables off |
| clk_ab_i | input | 2 | Per-channel capture clock for the A-side register |
| clk_ba_i | input | 2 | Per-channel capture clock for the B-side register |
| sel_ab_i | input | 2 | Per-channel B-bus source: 0 live A, 1 stored A |
| sel_ba_i | input | 2 | Per-channel A-bus source: 0 live B, 1 stored B |
| en_ab_i | input | 2 | Per-channel B-bus drive enable, active high |
| en_ba_ni | input | 2 | Per-channel A-bus drive enable, active low |
| a_i | input | 16 | Resolved A-bus value |
| a_o | output | 16 | Value offered to the A bus |
| a_oe_o | output | 16 | Per-bit A-bus drive enable |
| b_i | input | 16 | Resolved B-bus value |
| b_o | output | 16 | Value offered to the B bus |
| b_oe_o | output | 16 | Per-bit B-bus drive enable |

## Verification
The hardest case to reach from the ports is the two-way hold loop. In that case the only thing keeping a bus value is the block feeding it back to itself. The bench resolves both buses procedurally: an external driver wins, then the transceiver if it is enabled, then the previous bus value. It iterates this resolution until it settles. The stimulus drives one bus from outside with both paths live and enabled, then releases the driver and checks that both buses still carry the value. It repeats this from the B side and then drops power-good to break the loop.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  parameter int unsigned XCVR_LANE_W = 8;
  parameter int unsigned XCVR_LANES  = 2;
endpackage

// File: rtl/xcvr_dir.sv
// One transfer direction: capture register, live/stored mux, drive gate.
module xcvr_dir #(
  parameter int unsigned W = 8
) (
  input  logic         cap_clk_i,
  input  logic         pwr_good_i,
  input  logic [W-1:0] src_i,
  input  logic         use_store_i,
  input  logic         drive_i,
  output logic [W-1:0] dst_o,
  output logic [W-1:0] dst_oe_o
);
  logic [W-1:0] store_q;

  // no reset on storage: contents valid only after a capture edge
  always_ff @(posedge cap_clk_i) store_q <= src_i;

  assign dst_o    = use_store_i ? store_q : src_i;
  assign dst_oe_o = {W{drive_i & pwr_good_i}};

  // tracks that at least one edge has loaded the register since power-up
  logic primed_q;
  always_ff @(posedge cap_clk_i or negedge pwr_good_i) begin
    if (!pwr_good_i) primed_q <= 1'b0;
    else             primed_q <= 1'b1;
  end

  AST_STORED_OUT: assert property (@(posedge cap_clk_i) disable iff (!pwr_good_i)
    (primed_q && use_store_i) |-> (dst_o == $past(src_i))); // R2 R4 R5
endmodule

// File: rtl/xcvr_lane.sv
// One byte channel: A->B and B->A paths with independent controls.
module xcvr_lane #(
  parameter int unsigned W = 8
) (
  input  logic         pwr_good_i,
  input  logic         clk_ab_i,
  input  logic         clk_ba_i,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i,
  input  logic         en_ab_i,
  input  logic         en_ba_ni,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic [W-1:0] b_oe_o
);
  xcvr_dir #(.W(W)) i_dir_ab (
    .cap_clk_i  (clk_ab_i),
    .pwr_good_i (pwr_good_i),
    .src_i      (a_i),
    .use_store_i(sel_ab_i),
    .drive_i    (en_ab_i),
    .dst_o      (b_o),
    .dst_oe_o   (b_oe_o)
  );

  xcvr_dir #(.W(W)) i_dir_ba (
    .cap_clk_i  (clk_ba_i),
    .pwr_good_i (pwr_good_i),
    .src_i      (b_i),
    .use_store_i(sel_ba_i),
    .drive_i    (~en_ba_ni),
    .dst_o      (a_o),
    .dst_oe_o   (a_oe_o)
  );

  // both live and both driving: each side mirrors the other bus
  always_comb begin
    if (pwr_good_i && !sel_ab_i && !sel_ba_i && en_ab_i && !en_ba_ni) begin
      AST_HOLD_LOOP: assert ((b_o == a_i) && (a_o == b_i) && (&a_oe_o) && (&b_oe_o)); // R9
    end
  end
endmodule

// File: rtl/reg_xcvr.sv
module reg_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned LANE_W = XCVR_LANE_W,
  parameter int unsigned LANES  = XCVR_LANES,
  localparam int unsigned BUS_W = LANE_W * LANES
) (
  input  logic             pwr_good_i,
  input  logic [LANES-1:0] clk_ab_i,
  input  logic [LANES-1:0] clk_ba_i,
  input  logic [LANES-1:0] sel_ab_i,
  input  logic [LANES-1:0] sel_ba_i,
  input  logic [LANES-1:0] en_ab_i,
  input  logic [LANES-1:0] en_ba_ni,
  input  logic [BUS_W-1:0] a_i,
  output logic [BUS_W-1:0] a_o,
  output logic [BUS_W-1:0] a_oe_o,
  input  logic [BUS_W-1:0] b_i,
  output logic [BUS_W-1:0] b_o,
  output logic [BUS_W-1:0] b_oe_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    xcvr_lane #(.W(LANE_W)) i_lane (
      .pwr_good_i(pwr_good_i),
      .clk_ab_i  (clk_ab_i[g]),
      .clk_ba_i  (clk_ba_i[g]),
      .sel_ab_i  (sel_ab_i[g]),
      .sel_ba_i  (sel_ba_i[g]),
      .en_ab_i   (en_ab_i[g]),
      .en_ba_ni  (en_ba_ni[g]),
      .a_i       (a_i[g*LANE_W +: LANE_W]),
      .a_o       (a_o[g*LANE_W +: LANE_W]),
      .a_oe_o    (a_oe_o[g*LANE_W +: LANE_W]),
      .b_i       (b_i[g*LANE_W +: LANE_W]),
      .b_o       (b_o[g*LANE_W +: LANE_W]),
      .b_oe_o    (b_oe_o[g*LANE_W +: LANE_W])
    );
  end

  always_comb begin
    if (!pwr_good_i) begin
      AST_PWR_OFF_A: assert (a_oe_o == '0); // R8
      AST_PWR_OFF_B: assert (b_oe_o == '0); // R8
    end
  end
endmodule

// File: tb/test_reg_xcvr.sv
module test_reg_xcvr;
  localparam int unsigned LW = 8;
  localparam int unsigned NL = 2;
  localparam int unsigned BW = LW * NL;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          pwr_good;
  logic [NL-1:0] clk_ab, clk_ba, sel_ab, sel_ba, en_ab, en_ba_n;
  logic [BW-1:0] bus_a, bus_b, a_o, a_oe, b_o, b_oe;
  logic [BW-1:0] ext_a, ext_b, ext_a_en, ext_b_en;

  int vectors = 0;
  int errors  = 0;

  reg_xcvr i_reg_xcvr (
    .pwr_good_i(pwr_good),
    .clk_ab_i  (clk_ab),
    .clk_ba_i  (clk_ba),
    .sel_ab_i  (sel_ab),
    .sel_ba_i  (sel_ba),
    .en_ab_i   (en_ab),
    .en_ba_ni  (en_ba_n),
    .a_i       (bus_a),
    .a_o       (a_o),
    .a_oe_o    (a_oe),
    .b_i       (bus_b),
    .b_o       (b_o),
    .b_oe_o    (b_oe)
  );

  function automatic logic [LW-1:0] byte_of(logic [BW-1:0] v, int c);
    return v[c*LW +: LW];
  endfunction

  task automatic check(string req, logic [LW-1:0] act, logic [LW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // external driver wins, then transceiver, then previous bus value
  task automatic settle();
    for (int i = 0; i < 6; i++) begin
      logic [BW-1:0] na, nb;
      #1;
      na = (ext_a_en & ext_a) | (~ext_a_en & a_oe & a_o) | (~ext_a_en & ~a_oe & bus_a);
      nb = (ext_b_en & ext_b) | (~ext_b_en & b_oe & b_o) | (~ext_b_en & ~b_oe & bus_b);
      bus_a = na;
      bus_b = nb;
    end
    #1;
  endtask

  task automatic set_ch(int c, logic sab, logic sba, logic eab, logic eban);
    sel_ab[c] = sab; sel_ba[c] = sba; en_ab[c] = eab; en_ba_n[c] = eban;
  endtask

  task automatic drv_a(int c, logic [LW-1:0] v, logic on);
    ext_a[c*LW +: LW] = v; ext_a_en[c*LW +: LW] = {LW{on}};
  endtask

  task automatic drv_b(int c, logic [LW-1:0] v, logic on);
    ext_b[c*LW +: LW] = v; ext_b_en[c*LW +: LW] = {LW{on}};
  endtask

  task automatic pulse_ab(int c);
    clk_ab[c] = 1'b1; #3; clk_ab[c] = 1'b0; #3;
  endtask

  task automatic pulse_ba(int c);
    clk_ba[c] = 1'b1; #3; clk_ba[c] = 1'b0; #3;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    pwr_good = 1'b1;
    clk_ab = '0; clk_ba = '0; sel_ab = '0; sel_ba = '0;
    en_ab = '1; en_ba_n = '0;
    bus_a = '0; bus_b = '0; ext_a = '0; ext_b = '0; ext_a_en = '1; ext_b_en = '1;
    #1 pwr_good = 1'b0;
    settle();
    // power-off state with every enable requested
    for (int c = 0; c < NL; c++) begin
      check("R8 a_oe off", byte_of(a_oe, c), '0);
      check("R8 b_oe off", byte_of(b_oe, c), '0);
    end
    pwr_good = 1'b1;
    ext_a_en = '0; ext_b_en = '0;
    for (int c = 0; c < NL; c++) set_ch(c, 1'b0, 1'b0, 1'b0, 1'b1);
    settle();
    for (int c = 0; c < NL; c++) begin
      check("R6 b_oe low en", byte_of(b_oe, c), '0);
      check("R7 a_oe high en_n", byte_of(a_oe, c), '0);
    end

    for (int c = 0; c < NL; c++) begin
      for (int k = 0; k < 8; k++) begin
        logic [LW-1:0] v, w;
        v = LW'(k * 53 + c * 17 + 5);
        w = LW'(k * 29 + c * 71 + 200);
        // A -> B
        set_ch(c, 1'b0, 1'b0, 1'b1, 1'b1);
        drv_b(c, '0, 1'b0);
        drv_a(c, v, 1'b1);
        settle();
        check("R4 live b_o", byte_of(b_o, c), v);
        check("R6 b_oe on", byte_of(b_oe, c), '1);
        check("R7 a_oe off", byte_of(a_oe, c), '0);
        pulse_ab(c);
        drv_a(c, ~v, 1'b1);
        sel_ab[c] = 1'b1;
        settle();
        check("R2 R4 stored b_o", byte_of(b_o, c), v);
        check("R4 stored on bus", byte_of(bus_b, c), v);
        // capture with path disabled and select live
        set_ch(c, 1'b0, 1'b0, 1'b0, 1'b1);
        drv_a(c, w, 1'b1);
        settle();
        pulse_ab(c);
        check("R3 R6 b_oe disabled", byte_of(b_oe, c), '0);
        drv_a(c, ~w, 1'b1);
        set_ch(c, 1'b1, 1'b0, 1'b1, 1'b1);
        settle();
        check("R3 capture while off", byte_of(b_o, c), w);
        // B -> A
        set_ch(c, 1'b0, 1'b0, 1'b0, 1'b0);
        drv_a(c, '0, 1'b0);
        drv_b(c, w, 1'b1);
        settle();
        check("R5 live a_o", byte_of(a_o, c), w);
        check("R7 a_oe on", byte_of(a_oe, c), '1);
        check("R5 live on bus", byte_of(bus_a, c), w);
        pulse_ba(c);
        drv_b(c, ~w, 1'b1);
        sel_ba[c] = 1'b1;
        settle();
        check("R2 R5 stored a_o", byte_of(a_o, c), w);
        set_ch(c, 1'b0, 1'b1, 1'b0, 1'b1);
        drv_b(c, v, 1'b1);
        settle();
        pulse_ba(c);
        check("R3 R7 a_oe disabled", byte_of(a_oe, c), '0);
        drv_b(c, ~v, 1'b1);
        en_ba_n[c] = 1'b0;
        settle();
        check("R3 capture while off", byte_of(a_o, c), v);
        // two-way hold loop
        set_ch(c, 1'b0, 1'b0, 1'b1, 1'b0);
        drv_b(c, '0, 1'b0);
        drv_a(c, v, 1'b1);
        settle();
        check("R9 loop b bus", byte_of(bus_b, c), v);
        drv_a(c, '0, 1'b0);
        settle();
        check("R9 hold a bus", byte_of(bus_a, c), v);
        check("R9 hold b bus", byte_of(bus_b, c), v);
        drv_b(c, w, 1'b1);
        settle();
        drv_b(c, '0, 1'b0);
        settle();
        check("R9 hold a from b", byte_of(bus_a, c), w);
        check("R9 hold b from b", byte_of(bus_b, c), w);
      end
      // power loss breaks the loop drive
      pwr_good = 1'b0;
      settle();
      check("R8 a_oe loop off", byte_of(a_oe, c), '0);
      check("R8 b_oe loop off", byte_of(b_oe, c), '0);
      pwr_good = 1'b1;
      set_ch(c, 1'b0, 1'b0, 1'b0, 1'b1);
      settle();
    end

    // channel independence, both orientations
    for (int c = 0; c < NL; c++) begin
      int o;
      logic [LW-1:0] v;
      o = 1 - c;
      v = LW'(8'h3C + c * 8'h41);
      set_ch(c, 1'b0, 1'b0, 1'b1, 1'b1);
      drv_b(c, '0, 1'b0);
      drv_a(c, v, 1'b1);
      settle();
      pulse_ab(c);
      sel_ab[c] = 1'b1;
      drv_a(c, ~v, 1'b1);
      settle();
      for (int m = 0; m < 16; m++) begin
        set_ch(o, m[0], m[1], m[2], m[3]);
        drv_a(o, LW'(m * 19), 1'b1);
        drv_b(o, LW'(m * 23 + 1), !m[2]);
        settle();
        pulse_ab(o);
        pulse_ba(o);
        settle();
        check("R1 b_o untouched", byte_of(b_o, c), v);
        check("R1 b_oe untouched", byte_of(b_oe, c), '1);
        check("R1 a_oe untouched", byte_of(a_oe, c), '0);
      end
      set_ch(o, 1'b0, 1'b0, 1'b0, 1'b1);
      drv_a(o, '0, 1'b0);
      drv_b(o, '0, 1'b0);
      set_ch(c, 1'b0, 1'b0, 1'b0, 1'b1);
      drv_a(c, '0, 1'b0);
      settle();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule